// File: doc/BRIEF.md
# Byte/Word Configurable Read-Only Memory Device Model

This block models a parallel read-only memory as it appears at its pins, in a form that can be synthesized. A mode input chooses between a 16-bit word organisation and an 8-bit byte organisation. One shared pin plays two roles. In word mode it is data bit 15. In byte mode it is the address input that picks which half of the addressed word is read. A chip-enable and an output-enable, both active low, must both be asserted before any data bit is driven. The tri-state bus is shown as a 16-bit value plus a 16-bit per-bit drive-enable vector. The shared pin therefore has an input port for its address role and uses bit 15 of the output pair for its data role.

The array covers 2^19 word addresses. Each word is computed from its address and a seed parameter, so no large storage is elaborated and every read can be predicted. The word at address `a` is `a[15:0] ^ SEED ^ {a[18:16], 13'b0}`, and SEED defaults to 16'h5A3C. A digital identification input stands in for a high-voltage detector. When it is set in word organisation, the block returns a manufacturer code (0x20) or a device code (0xB2) in place of array data.

The pins are sampled on each rising clock edge, and the bus reflects them from that edge on. The control pins are plain levels. There is no handshake, because the device has no flow control of its own.

Top module: `cfgrom_dev`

## Requirements
- R1: While reset is asserted, and on the first edge after reset is released, every drive-enable bit is 0 and the data value is 0.
- R2: With chip-enable high (standby), all 16 drive-enable bits are 0 whatever the output-enable and identification levels.
- R3: With chip-enable low and output-enable high, all 16 drive-enable bits are 0.
- R4: A word read (both enables low, word_mode=1, id_mode=0) drives all 16 bits with the word at `addr`. The shared-pin input has no effect in this mode.
- R5: A byte read (both enables low, word_mode=0) with the shared-pin input at 0 drives bits 7..0 with bits 7..0 of the addressed word. Drive-enable is 16'h00FF.
- R6: A byte read with the shared-pin input at 1 drives bits 7..0 with bits 15..8 of the addressed word. Drive-enable is 16'h00FF.
- R7: An identification read (both enables low, word_mode=1, id_mode=1) with addr bit 0 at 0 drives 16'h2020 on all 16 bits. The other address bits have no effect.
- R8: An identification read with addr bit 0 at 1 drives 16'hB2B2 on all 16 bits.
- R9: id_mode has no effect in byte organisation. The result is the ordinary byte read of R5 or R6.
- R10: The bus shows the pins sampled at the most recent rising edge, which is a latency of exactly one edge.
- R11: Every data bit whose drive-enable is 0 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| id_mode | input | 1 | Identification request (stands in for the high-voltage detect) |
| addr | input | 19 | Word address |
| dq15_lsb_in | input | 1 | Shared pin in its address role: byte half select |
| dq_out | output | 16 | Data bus value |
| dq_oe | output | 16 | Per-bit drive enable of the data bus |

## Verification
The identification request can arrive in the same cycle as a byte-organisation read, and in the same cycle as standby. The bench provokes both by raising id_mode together with word_mode=0, and together with ce_n=1. It judges the first case against the plain byte read and the second against a fully undriven bus. A further collision is the shared pin toggling during word reads. The bench sets the shared-pin input to each level in those cycles and expects the word data to be unchanged.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'd0,
    SEL_WORD = 2'd1,
    SEL_BYTE = 2'd2,
    SEL_ID   = 2'd3
  } bus_sel_e;
endpackage

// File: rtl/cfgrom_decode.sv
module cfgrom_decode
  import cfgrom_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     word_mode,
  input  logic     id_mode,
  output bus_sel_e sel
);
  always_comb begin
    if (ce_n || oe_n)   sel = SEL_OFF;
    else if (!word_mode) sel = SEL_BYTE;
    else if (id_mode)    sel = SEL_ID;
    else                 sel = SEL_WORD;
  end
endmodule

// File: rtl/cfgrom_array.sv
module cfgrom_array #(
  parameter int          AW   = 19,
  parameter int          DW   = 16,
  parameter logic [15:0] SEED = 16'h5A3C
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int HI_W = AW - DW;
  logic [DW-1:0] hi_part;
  generate
    if (HI_W > 0) begin : g_fold
      assign hi_part = {addr[AW-1:DW], {(DW-HI_W){1'b0}}};
    end else begin : g_nofold
      assign hi_part = '0;
    end
  endgenerate
  assign word = addr[DW-1:0] ^ SEED[DW-1:0] ^ hi_part;
endmodule

// File: rtl/cfgrom_lanes.sv
module cfgrom_lanes
  import cfgrom_pkg::*;
#(
  parameter int         DW       = 16,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_sel_e      sel,
  input  logic [DW-1:0] word,
  input  logic          half_sel,
  input  logic          code_sel,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);
  localparam int LANES = DW / 8;
  logic [7:0] id_code;
  logic [7:0] byte_pick;
  assign id_code   = code_sel ? DEV_CODE : MFR_CODE;
  assign byte_pick = word[8*int'(half_sel) +: 8];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] nxt_d;
    logic       nxt_e;
    always_comb begin
      nxt_d = 8'h00;
      nxt_e = 1'b0;
      unique case (sel)
        SEL_WORD: begin nxt_d = word[8*i +: 8]; nxt_e = 1'b1; end
        SEL_ID:   begin nxt_d = id_code;        nxt_e = 1'b1; end
        SEL_BYTE: if (i == 0) begin nxt_d = byte_pick; nxt_e = 1'b1; end
        default:  ;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dq_out[8*i +: 8] <= 8'h00;
        dq_oe[8*i +: 8]  <= 8'h00;
      end else begin
        dq_out[8*i +: 8] <= nxt_d;
        dq_oe[8*i +: 8]  <= {8{nxt_e}};
      end
    end
  end
endmodule

// File: rtl/cfgrom_dev.sv
module cfgrom_dev
  import cfgrom_pkg::*;
#(
  parameter int          AW       = 19,
  parameter int          DW       = 16,
  parameter logic [15:0] SEED     = 16'h5A3C,
  parameter logic [7:0]  MFR_CODE = 8'h20,
  parameter logic [7:0]  DEV_CODE = 8'hB2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          word_mode,
  input  logic          id_mode,
  input  logic [AW-1:0] addr,
  input  logic          dq15_lsb_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] dq_oe
);
  bus_sel_e      sel;
  logic [DW-1:0] word;

  cfgrom_decode u_decode (
    .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode), .id_mode(id_mode), .sel(sel)
  );

  cfgrom_array #(.AW(AW), .DW(DW), .SEED(SEED)) u_array (
    .addr(addr), .word(word)
  );

  cfgrom_lanes #(.DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_lanes (
    .clk(clk), .rst_n(rst_n), .sel(sel), .word(word),
    .half_sel(dq15_lsb_in), .code_sel(addr[0]),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/cfgrom_dev_chk.sv
module cfgrom_dev_chk #(
  parameter int         AW       = 19,
  parameter int         DW       = 16,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hB2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          word_mode,
  input logic          id_mode,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dq_out,
  input logic [DW-1:0] dq_oe
);
  logic live;
  always_ff @(posedge clk) live <= rst_n;

  // R2
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && $past(ce_n) |-> dq_oe == '0);
  // R3
  out_disable_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ce_n) && $past(oe_n) |-> dq_oe == '0);
  // R4
  word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ce_n) && !$past(oe_n) && $past(word_mode) |-> dq_oe == '1);
  // R5
  byte_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ce_n) && !$past(oe_n) && !$past(word_mode) |-> dq_oe == 16'h00FF);
  // R7
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ce_n) && !$past(oe_n) && $past(word_mode) && $past(id_mode)
    && !$past(addr[0]) |-> dq_out == {MFR_CODE, MFR_CODE});
  // R8
  id_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && !$past(ce_n) && !$past(oe_n) && $past(word_mode) && $past(id_mode)
    && $past(addr[0]) |-> dq_out == {DEV_CODE, DEV_CODE});
  // R11
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~dq_oe) == '0);
endmodule

bind cfgrom_dev cfgrom_dev_chk #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
  .id_mode(id_mode), .addr(addr), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/cfgrom_dev_bench.sv
`timescale 1ns/100ps
module cfgrom_dev_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, word_mode = 1'b1, id_mode = 1'b0, dq15_lsb_in = 1'b0;
  logic [18:0] addr = '0;
  logic [15:0] dq_out, dq_oe;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  typedef struct {
    logic [15:0] d;
    logic [15:0] e;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cfgrom_dev u_cfgrom_dev (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
    .id_mode(id_mode), .addr(addr), .dq15_lsb_in(dq15_lsb_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [15:0] ref_word(logic [18:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[18:16], 13'b0};
  endfunction

  task automatic cmp(string tag, logic [15:0] d, logic [15:0] e, logic [15:0] xd, logic [15:0] xe);
    checks++;
    if (d !== xd || e !== xe) begin
      fails++;
      $display("FAIL %s: dq=%h oe=%h expected dq=%h oe=%h", tag, d, e, xd, xe);
    end
  endtask

  // Drives one set of pins at a falling edge and queues the result due after the next rising edge (R10).
  task automatic drive(string tag, logic c, logic o, logic w, logic id, logic [18:0] a, logic h,
                       logic [15:0] xd, logic [15:0] xe);
    exp_t it;
    @(negedge clk);
    ce_n = c; oe_n = o; word_mode = w; id_mode = id; addr = a; dq15_lsb_in = h;
    it.d = xd; it.e = xe; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        cmp(it.tag, dq_out, dq_oe, it.d, it.e);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: dq=%h oe=%h expected completion", dq_out, dq_oe);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [18:0] a;
    // R1: reset state with active read pins applied
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 cmp("R1 in reset", dq_out, dq_oe, 16'h0000, 16'h0000);
    @(negedge clk); rst_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1 cmp("R1 first edge", dq_out, dq_oe, 16'h0000, 16'h0000);

    // R4 word reads, shared pin toggled (no effect)
    a = 19'h00000; drive("R4 word addr0", 0, 0, 1, 0, a, 0, ref_word(a), 16'hFFFF);
    a = 19'h7FFFF; drive("R4 word top", 0, 0, 1, 0, a, 1, ref_word(a), 16'hFFFF);
    a = 19'h12345; drive("R4 word mid pin1", 0, 0, 1, 0, a, 1, ref_word(a), 16'hFFFF);
    a = 19'h12345; drive("R4 word mid pin0", 0, 0, 1, 0, a, 0, ref_word(a), 16'hFFFF);
    // R2 standby, with output enable low and with id request
    drive("R2 standby oe low", 1, 0, 1, 0, 19'h00055, 0, 16'h0000, 16'h0000);
    drive("R2 standby id", 1, 0, 1, 1, 19'h00001, 0, 16'h0000, 16'h0000);
    drive("R2 standby oe high", 1, 1, 0, 0, 19'h00055, 1, 16'h0000, 16'h0000);
    // R3 output disable
    drive("R3 disable word", 0, 1, 1, 0, 19'h0ABCD, 0, 16'h0000, 16'h0000);
    drive("R3 disable byte", 0, 1, 0, 0, 19'h0ABCD, 1, 16'h0000, 16'h0000);
    // R5 / R6 byte reads, R11 upper bits zero
    a = 19'h4F0E1; drive("R5 byte low", 0, 0, 0, 0, a, 0, {8'h00, ref_word(a)[7:0]}, 16'h00FF);
    a = 19'h4F0E1; drive("R6 byte high", 0, 0, 0, 0, a, 1, {8'h00, ref_word(a)[15:8]}, 16'h00FF);
    a = 19'h7FFFF; drive("R6 byte high top", 0, 0, 0, 0, a, 1, {8'h00, ref_word(a)[15:8]}, 16'h00FF);
    a = 19'h00000; drive("R5 byte low zero", 0, 0, 0, 0, a, 0, {8'h00, ref_word(a)[7:0]}, 16'h00FF);
    // R7 / R8 identification
    drive("R7 id mfr", 0, 0, 1, 1, 19'h00000, 0, 16'h2020, 16'hFFFF);
    drive("R8 id dev", 0, 0, 1, 1, 19'h00001, 0, 16'hB2B2, 16'hFFFF);
    drive("R7 id mfr other bits", 0, 0, 1, 1, 19'h7FFFE, 1, 16'h2020, 16'hFFFF);
    drive("R8 id dev other bits", 0, 0, 1, 1, 19'h2AAAB, 1, 16'hB2B2, 16'hFFFF);
    // R9 id ignored in byte organisation
    a = 19'h00001; drive("R9 id byte low", 0, 0, 0, 1, a, 0, {8'h00, ref_word(a)[7:0]}, 16'h00FF);
    a = 19'h00000; drive("R9 id byte high", 0, 0, 0, 1, a, 1, {8'h00, ref_word(a)[15:8]}, 16'h00FF);
    // R10 back-to-back changes land one edge later each
    a = 19'h31337; drive("R10 word after byte", 0, 0, 1, 0, a, 0, ref_word(a), 16'hFFFF);
    drive("R10 disable after word", 0, 1, 1, 0, a, 0, 16'h0000, 16'h0000);
    for (int k = 0; k < 8; k++) begin
      logic [18:0] b;
      b = 19'(k * 19'h0F1D3 + 19'h00101);
      drive("R4 word sweep", 0, 0, 1, 0, b, k[0], ref_word(b), 16'hFFFF);
      drive("R6 byte sweep", 0, 0, 0, 0, b, k[1],
            {8'h00, k[1] ? ref_word(b)[15:8] : ref_word(b)[7:0]}, 16'h00FF);
    end
    drive("R2 final standby", 1, 1, 1, 0, 19'h0, 0, 16'h0000, 16'h0000);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule